// File: doc/BRIEF.md
# Trigger Request Handshake Controller

This block runs one trigger cycle at a time for a detector read-out that shares a single dead time. An external request is taken only while the block is idle. It is passed on as a one-cycle pulse to the trigger-node port. The block then waits for the node's local-trigger strobe and the timestamp that follows it. After that it waits for the node's verdict, which is a validate or reject flag, and then for a tag that repeats the timestamp and adds an event number. Busy stays high for the whole cycle, and requests that arrive in that time are turned away.

Both tags arrive on one shared 16-bit word bus, with a valid strobe, least significant word first. The local-trigger time and the verdict are held in status registers, each with a ready flag that a host read strobe clears. If no verdict comes within a set number of cycles after the local trigger, the block raises a timeout pulse, drives a reset output for a fixed length and then frees itself. Five wrapping counters record requests, local triggers, validations, rejections and busy periods.

Top module: `trig_hs_ctrl`

## Requirements
- R1: After reset, busy_o, node_req_o, lt_rdy_o, val_rdy_o, mismatch_o, timeout_o and reset_o are 0 and all five scalers read 0.
- R2: A request (req_i high) sampled while idle produces node_req_o high for exactly the next cycle, and busy_o rises in that same cycle.
- R3: A request sampled while busy_o is high produces no node_req_o pulse and does not add to the busy scaler.
- R4: After an accepted request, lt_i is taken at one edge. The next three tag words then form the 48-bit time, with the first word as bits 15:0. When the third word is taken, lt_tag_o holds that time and lt_rdy_o is 1.
- R5: After the local-trigger tag, res_vld_i is taken with res_acc_i (1 means validate, 0 means reject). Five tag words follow: three time words and then two event-number words, each group least significant word first. At the fifth word busy_o falls, val_rdy_o is 1, and val_acc_o, val_time_o and val_evt_o hold the verdict.
- R6: If no verdict is taken within TIMEOUT_CYC edges after the edge that took lt_i, timeout_o pulses for one cycle. reset_o is then high for RST_LEN cycles starting in that same cycle. busy_o stays high until reset_o falls. val_rdy_o is not set.
- R7: If the time in the verdict tag differs from the latched local-trigger time, mismatch_o becomes 1 and stays 1 until reset. The cycle still ends normally.
- R8: lt_rd_i clears lt_rdy_o and val_rd_i clears val_rdy_o at the next edge. A set at the same edge takes priority over the clear.
- R9: The scalers count cycles with req_i high (including refused requests), accepted local triggers, validations, rejections and accepted requests (busy periods).
- R10: lt_i outside the wait-for-local-trigger phase, and res_vld_i outside the wait-for-verdict phase, are ignored. They change neither the state nor the scalers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | External trigger request strobe |
| node_req_o | output | 1 | Request pulse to the trigger node |
| lt_i | input | 1 | Local-trigger strobe from the node |
| tag_vld_i | input | 1 | Tag word valid |
| tag_word_i | input | WORD_W | Tag word, least significant first |
| res_vld_i | input | 1 | Verdict flag strobe |
| res_acc_i | input | 1 | Verdict: 1 validate, 0 reject |
| busy_o | output | 1 | Cycle in progress, requests refused |
| timeout_o | output | 1 | One-cycle verdict timeout pulse |
| reset_o | output | 1 | Reset output after a timeout |
| lt_rd_i | input | 1 | Host read of the local-trigger tag |
| lt_rdy_o | output | 1 | Local-trigger tag ready |
| lt_tag_o | output | TIME_W | Latched local-trigger time |
| val_rd_i | input | 1 | Host read of the verdict tag |
| val_rdy_o | output | 1 | Verdict ready |
| val_acc_o | output | 1 | Latched verdict |
| val_time_o | output | TIME_W | Time from the verdict tag |
| val_evt_o | output | EVT_W | Event number from the verdict tag |
| mismatch_o | output | 1 | Sticky time-mismatch flag |
| cnt_req_o | output | SCALER_W | Request scaler |
| cnt_lt_o | output | SCALER_W | Local-trigger scaler |
| cnt_val_o | output | SCALER_W | Validation scaler |
| cnt_rej_o | output | SCALER_W | Rejection scaler |
| cnt_busy_o | output | SCALER_W | Busy-period scaler |

## Verification
The bench sends a second request just after one has been accepted. A design that let it through would pulse node_req_o twice and count two busy periods. It also sends a stray verdict while the block waits for the local trigger, and a stray local trigger while it is idle. A design that acted on either would fall out of sequence and miscount. The timeout is checked edge by edge: one edge too early or too late shows up in timeout_o, and a design that freed itself before the reset finished would drop busy_o while reset_o is still high. One table entry sends a verdict time that differs from the local-trigger time, and the next good cycle then shows whether the error flag stays set.

// File: rtl/trig_hs_pkg.sv
package trig_hs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT_LT, ST_LT_TAG, ST_WAIT_RES, ST_RES_TAG, ST_RST
  } cyc_state_e;

  localparam int SC_REQ  = 0;
  localparam int SC_LT   = 1;
  localparam int SC_VAL  = 2;
  localparam int SC_REJ  = 3;
  localparam int SC_BUSY = 4;
  localparam int SC_NUM  = 5;
endpackage

// File: rtl/tag_shifter.sv
module tag_shifter #(
  parameter int WORD_W = 16,
  parameter int NWORDS = 3,
  localparam int OUT_W = WORD_W * NWORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [OUT_W-1:0]  nxt_o
);
  // keeps NWORDS-1 older words; nxt_o is the full tag including the word now on the bus
  logic [WORD_W-1:0] s_q [NWORDS-1];

  for (genvar k = 0; k < NWORDS - 1; k++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) s_q[k] <= '0;
      else if (shift_i) begin
        if (k == NWORDS - 2) s_q[k] <= word_i;
        else s_q[k] <= s_q[k+1];
      end
    end
    assign nxt_o[k*WORD_W +: WORD_W] = s_q[k];
  end
  assign nxt_o[(NWORDS-1)*WORD_W +: WORD_W] = word_i;
endmodule

// File: rtl/event_scaler.sv
module event_scaler #(
  parameter int NUM = 5,
  parameter int CNT_W = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM-1:0]            inc_i,
  output logic [NUM-1:0][CNT_W-1:0] cnt_o
);
  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_o[g] <= '0;
      else if (inc_i[g]) cnt_o[g] <= cnt_o[g] + 1'b1;
    end
  end
endmodule

// File: rtl/trig_seq_fsm.sv
module trig_seq_fsm
  import trig_hs_pkg::*;
#(
  parameter int LT_WORDS = 3,
  parameter int RES_WORDS = 5,
  parameter int TIMEOUT_CYC = 2000,
  parameter int RST_LEN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              lt_i,
  input  logic              tag_vld_i,
  input  logic              res_vld_i,
  input  logic              res_acc_i,
  output logic              node_req_o,
  output logic              busy_o,
  output logic              reset_o,
  output logic              timeout_o,
  output logic              lt_shift_o,
  output logic              lt_done_o,
  output logic              res_shift_o,
  output logic              res_done_o,
  output logic              acc_o,
  output logic [SC_NUM-1:0] ev_o
);
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
  localparam int WC_W  = $clog2(RES_WORDS + LT_WORDS + 1);
  localparam int RC_W  = $clog2(RST_LEN + 1);

  cyc_state_e       state_q, state_d;
  logic [TMR_W-1:0] tmr_q;
  logic [WC_W-1:0]  wc_q;
  logic [RC_W-1:0]  rc_q;
  logic             node_req_q, timeout_q, acc_q;
  logic             tmr_exp;

  assign tmr_exp = tmr_q >= TMR_W'(TIMEOUT_CYC - 1);

  always_comb begin
    state_d     = state_q;
    lt_shift_o  = 1'b0;
    lt_done_o   = 1'b0;
    res_shift_o = 1'b0;
    res_done_o  = 1'b0;
    ev_o        = '0;
    ev_o[SC_REQ] = req_i;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        state_d = ST_WAIT_LT;
        ev_o[SC_BUSY] = 1'b1;
      end
      ST_WAIT_LT: if (lt_i) begin
        state_d = ST_LT_TAG;
        ev_o[SC_LT] = 1'b1;
      end
      ST_LT_TAG: begin
        lt_shift_o = tag_vld_i;
        if (tag_vld_i && wc_q == WC_W'(LT_WORDS - 1)) begin
          lt_done_o = 1'b1;
          state_d   = ST_WAIT_RES;
        end else if (tmr_exp) begin
          state_d = ST_RST;
        end
      end
      ST_WAIT_RES: begin
        if (res_vld_i) begin
          state_d = ST_RES_TAG;
          ev_o[SC_VAL] = res_acc_i;
          ev_o[SC_REJ] = !res_acc_i;
        end else if (tmr_exp) begin
          state_d = ST_RST;
        end
      end
      ST_RES_TAG: begin
        res_shift_o = tag_vld_i;
        if (tag_vld_i && wc_q == WC_W'(RES_WORDS - 1)) begin
          res_done_o = 1'b1;
          state_d    = ST_IDLE;
        end
      end
      ST_RST: if (rc_q == RC_W'(RST_LEN - 1)) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      tmr_q      <= '0;
      wc_q       <= '0;
      rc_q       <= '0;
      node_req_q <= 1'b0;
      timeout_q  <= 1'b0;
      acc_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      node_req_q <= (state_q == ST_IDLE) && req_i;
      timeout_q  <= (state_d == ST_RST) && (state_q != ST_RST);
      // timer runs from the local-trigger edge until the verdict flag
      if (state_q == ST_WAIT_LT) tmr_q <= '0;
      else if (state_q == ST_LT_TAG || state_q == ST_WAIT_RES) tmr_q <= tmr_q + 1'b1;
      if (state_d != state_q) wc_q <= '0;
      else if (tag_vld_i) wc_q <= wc_q + 1'b1;
      if (state_q != ST_RST) rc_q <= '0;
      else rc_q <= rc_q + 1'b1;
      if (state_q == ST_WAIT_RES && res_vld_i) acc_q <= res_acc_i;
    end
  end

  assign node_req_o = node_req_q;
  assign timeout_o  = timeout_q;
  assign busy_o     = state_q != ST_IDLE;
  assign reset_o    = state_q == ST_RST;
  assign acc_o      = acc_q;
endmodule

// File: rtl/trig_hs_ctrl.sv
module trig_hs_ctrl
  import trig_hs_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int TIME_W = 48,
  parameter int EVT_W = 32,
  parameter int SCALER_W = 32,
  parameter int TIMEOUT_CYC = 2000,
  parameter int RST_LEN = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  output logic                node_req_o,
  input  logic                lt_i,
  input  logic                tag_vld_i,
  input  logic [WORD_W-1:0]   tag_word_i,
  input  logic                res_vld_i,
  input  logic                res_acc_i,
  output logic                busy_o,
  output logic                timeout_o,
  output logic                reset_o,
  input  logic                lt_rd_i,
  output logic                lt_rdy_o,
  output logic [TIME_W-1:0]   lt_tag_o,
  input  logic                val_rd_i,
  output logic                val_rdy_o,
  output logic                val_acc_o,
  output logic [TIME_W-1:0]   val_time_o,
  output logic [EVT_W-1:0]    val_evt_o,
  output logic                mismatch_o,
  output logic [SCALER_W-1:0] cnt_req_o,
  output logic [SCALER_W-1:0] cnt_lt_o,
  output logic [SCALER_W-1:0] cnt_val_o,
  output logic [SCALER_W-1:0] cnt_rej_o,
  output logic [SCALER_W-1:0] cnt_busy_o
);
  localparam int LT_WORDS  = TIME_W / WORD_W;
  localparam int RES_WORDS = (TIME_W + EVT_W) / WORD_W;
  localparam int RES_W     = RES_WORDS * WORD_W;

  logic lt_shift, lt_done, res_shift, res_done, acc;
  logic [SC_NUM-1:0] ev;
  logic [SC_NUM-1:0][SCALER_W-1:0] cnt;
  logic [TIME_W-1:0] lt_nxt;
  logic [RES_W-1:0]  res_nxt;

  trig_seq_fsm #(
    .LT_WORDS(LT_WORDS), .RES_WORDS(RES_WORDS),
    .TIMEOUT_CYC(TIMEOUT_CYC), .RST_LEN(RST_LEN)
  ) i_fsm (
    .clk_i, .rst_ni, .req_i, .lt_i, .tag_vld_i, .res_vld_i, .res_acc_i,
    .node_req_o, .busy_o, .reset_o, .timeout_o,
    .lt_shift_o(lt_shift), .lt_done_o(lt_done),
    .res_shift_o(res_shift), .res_done_o(res_done),
    .acc_o(acc), .ev_o(ev)
  );

  tag_shifter #(.WORD_W(WORD_W), .NWORDS(LT_WORDS)) i_lt_tag (
    .clk_i, .rst_ni, .shift_i(lt_shift), .word_i(tag_word_i), .nxt_o(lt_nxt)
  );

  tag_shifter #(.WORD_W(WORD_W), .NWORDS(RES_WORDS)) i_res_tag (
    .clk_i, .rst_ni, .shift_i(res_shift), .word_i(tag_word_i), .nxt_o(res_nxt)
  );

  event_scaler #(.NUM(SC_NUM), .CNT_W(SCALER_W)) i_scaler (
    .clk_i, .rst_ni, .inc_i(ev), .cnt_o(cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lt_tag_o   <= '0;
      lt_rdy_o   <= 1'b0;
      val_time_o <= '0;
      val_evt_o  <= '0;
      val_acc_o  <= 1'b0;
      val_rdy_o  <= 1'b0;
      mismatch_o <= 1'b0;
    end else begin
      if (lt_done) begin
        lt_tag_o <= lt_nxt;
        lt_rdy_o <= 1'b1;
      end else if (lt_rd_i) begin
        lt_rdy_o <= 1'b0;
      end
      if (res_done) begin
        val_time_o <= res_nxt[TIME_W-1:0];
        val_evt_o  <= res_nxt[TIME_W +: EVT_W];
        val_acc_o  <= acc;
        val_rdy_o  <= 1'b1;
        if (res_nxt[TIME_W-1:0] != lt_tag_o) mismatch_o <= 1'b1;
      end else if (val_rd_i) begin
        val_rdy_o <= 1'b0;
      end
    end
  end

  assign cnt_req_o  = cnt[SC_REQ];
  assign cnt_lt_o   = cnt[SC_LT];
  assign cnt_val_o  = cnt[SC_VAL];
  assign cnt_rej_o  = cnt[SC_REJ];
  assign cnt_busy_o = cnt[SC_BUSY];
endmodule

// File: rtl/trig_hs_ctrl_chk.sv
module trig_hs_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic node_req_o,
  input logic busy_o,
  input logic timeout_o,
  input logic reset_o,
  input logic lt_rd_i,
  input logic lt_rdy_o,
  input logic val_rd_i,
  input logic val_rdy_o,
  input logic mismatch_o
);
  a_r2_pulse_starts_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    node_req_o |-> busy_o && !$past(busy_o));
  a_r3_refused_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && req_i |=> !node_req_o);
  a_r6_timeout_with_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> reset_o);
  a_r6_busy_covers_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_o |-> busy_o);
  a_r6_no_verdict_on_timeout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !$rose(val_rdy_o));
  a_r7_mismatch_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mismatch_o) |-> mismatch_o);
  a_r8_lt_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lt_rdy_o) |-> $past(lt_rd_i));
  a_r8_val_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(val_rdy_o) |-> $past(val_rd_i));
  a_r5_verdict_ends_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(val_rdy_o) |-> $fell(busy_o));
endmodule

bind trig_hs_ctrl trig_hs_ctrl_chk i_chk (.*);

// File: tb/test_trig_hs_ctrl.sv
module test_trig_hs_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 30;
  localparam int RLEN = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 0, lt_i = 0, tag_vld_i = 0, res_vld_i = 0, res_acc_i = 0;
  logic lt_rd_i = 0, val_rd_i = 0;
  logic [15:0] tag_word_i = '0;
  logic node_req_o, busy_o, timeout_o, reset_o, lt_rdy_o, val_rdy_o, val_acc_o, mismatch_o;
  logic [47:0] lt_tag_o, val_time_o;
  logic [31:0] val_evt_o;
  logic [15:0] cnt_req_o, cnt_lt_o, cnt_val_o, cnt_rej_o, cnt_busy_o;

  int nchecks = 0, nfail = 0;
  int exp_req = 0, exp_lt = 0, exp_val = 0, exp_rej = 0, exp_busy = 0;
  logic exp_mis = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_hs_ctrl #(.WORD_W(16), .TIME_W(48), .EVT_W(32), .SCALER_W(16),
                 .TIMEOUT_CYC(TMO), .RST_LEN(RLEN)) i_trig_hs_ctrl (
    .clk_i(clk), .rst_ni, .req_i, .node_req_o, .lt_i, .tag_vld_i, .tag_word_i,
    .res_vld_i, .res_acc_i, .busy_o, .timeout_o, .reset_o, .lt_rd_i, .lt_rdy_o,
    .lt_tag_o, .val_rd_i, .val_rdy_o, .val_acc_o, .val_time_o, .val_evt_o,
    .mismatch_o, .cnt_req_o, .cnt_lt_o, .cnt_val_o, .cnt_rej_o, .cnt_busy_o
  );

  // {accept, bad_time, time, event}
  localparam logic [81:0] VEC [4] = '{
    {1'b1, 1'b0, 48'h0000_1234_5678, 32'h0000_0001},
    {1'b0, 1'b0, 48'hFFFF_0000_FFFF, 32'hDEAD_BEEF},
    {1'b1, 1'b0, 48'hA5A5_5A5A_0F0F, 32'h8000_0000},
    {1'b0, 1'b1, 48'h0123_4567_89AB, 32'h0000_FFFF}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  endtask

  task automatic check_scalers(input string req);
    check(req, 96'(cnt_req_o), 96'(exp_req));
    check(req, 96'(cnt_lt_o), 96'(exp_lt));
    check(req, 96'(cnt_val_o), 96'(exp_val));
    check(req, 96'(cnt_rej_o), 96'(exp_rej));
    check(req, 96'(cnt_busy_o), 96'(exp_busy));
  endtask

  task automatic clear_ready();
    lt_rd_i = 1; val_rd_i = 1; tick(); lt_rd_i = 0; val_rd_i = 0;
  endtask

  task automatic run_cycle(input logic [47:0] t, input logic [31:0] e,
                           input logic acc, input logic bad);
    logic [47:0] vt;
    logic [79:0] words;
    clear_ready();
    req_i = 1; exp_req++; exp_busy++; tick(); req_i = 0;
    check("R2 node_req pulse", 96'(node_req_o), 96'(1));
    check("R2 busy rises", 96'(busy_o), 96'(1));
    req_i = 1; exp_req++; tick(); req_i = 0;
    check("R2 pulse one cycle", 96'(node_req_o), 96'(0));
    tick();
    check("R3 refused no pulse", 96'(node_req_o), 96'(0));
    check("R3 busy count kept", 96'(cnt_busy_o), 96'(exp_busy));
    res_vld_i = 1; res_acc_i = 1; tick(); res_vld_i = 0;  // R10 stray verdict
    lt_i = 1; exp_lt++; tick(); lt_i = 0;
    for (int w = 0; w < 3; w++) begin
      tag_vld_i = 1; tag_word_i = t[16*w +: 16]; tick();
    end
    tag_vld_i = 0;
    check("R4 lt ready", 96'(lt_rdy_o), 96'(1));
    check("R4 lt tag", 96'(lt_tag_o), 96'(t));
    tick();
    res_vld_i = 1; res_acc_i = acc;
    if (acc) exp_val++; else exp_rej++;
    tick(); res_vld_i = 0;
    vt = bad ? (t ^ 48'h1) : t;
    words = {e, vt};
    for (int w = 0; w < 5; w++) begin
      tag_vld_i = 1; tag_word_i = words[16*w +: 16];
      if (w < 4) begin
        tick();
        check("R5 busy until last word", 96'(busy_o), 96'(1));
      end else tick();
    end
    tag_vld_i = 0;
    exp_mis = exp_mis | bad;
    check("R5 busy falls", 96'(busy_o), 96'(0));
    check("R5 val ready", 96'(val_rdy_o), 96'(1));
    check("R5 verdict", 96'(val_acc_o), 96'(acc));
    check("R5 val time", 96'(val_time_o), 96'(vt));
    check("R5 val event", 96'(val_evt_o), 96'(e));
    check("R7 mismatch", 96'(mismatch_o), 96'(exp_mis));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1;
    tick();
    // R1 reset state
    check("R1 busy", 96'(busy_o), 96'(0));
    check("R1 node_req", 96'(node_req_o), 96'(0));
    check("R1 flags", 96'({lt_rdy_o, val_rdy_o, mismatch_o, timeout_o, reset_o}), 96'(0));
    check_scalers("R1 scalers");

    // R10 stray strobes while idle
    lt_i = 1; tick(); lt_i = 0;
    res_vld_i = 1; res_acc_i = 1; tick(); res_vld_i = 0;
    check("R10 idle lt ignored", 96'(cnt_lt_o), 96'(0));
    check("R10 idle verdict ignored", 96'(cnt_val_o), 96'(0));
    check("R10 still idle", 96'(busy_o), 96'(0));

    for (int i = 0; i < 4; i++)
      run_cycle(VEC[i][79:32], VEC[i][31:0], VEC[i][81], VEC[i][80]);
    check_scalers("R9 after table");

    // R7 flag stays after a good cycle
    run_cycle(48'h0000_0000_0042, 32'h7, 1'b1, 1'b0);
    check("R7 sticky", 96'(mismatch_o), 96'(1));

    // R8 read strobes
    lt_rd_i = 1; tick(); lt_rd_i = 0;
    check("R8 lt cleared", 96'(lt_rdy_o), 96'(0));
    check("R8 val untouched", 96'(val_rdy_o), 96'(1));
    val_rd_i = 1; tick(); val_rd_i = 0;
    check("R8 val cleared", 96'(val_rdy_o), 96'(0));

    // R6 timeout
    req_i = 1; exp_req++; exp_busy++; tick(); req_i = 0;
    lt_i = 1; exp_lt++; tick(); lt_i = 0;
    for (int k = 1; k <= TMO + RLEN; k++) begin
      if (k <= 3) begin tag_vld_i = 1; tag_word_i = 16'(k); end
      tick();
      tag_vld_i = 0;
      if (k == TMO - 1) check("R6 no early timeout", 96'(timeout_o), 96'(0));
      if (k == TMO) begin
        check("R6 timeout pulse", 96'(timeout_o), 96'(1));
        check("R6 reset starts", 96'(reset_o), 96'(1));
      end
      if (k == TMO + 1) check("R6 pulse one cycle", 96'(timeout_o), 96'(0));
      if (k == TMO + RLEN - 1) begin
        check("R6 reset held", 96'(reset_o), 96'(1));
        check("R6 busy held", 96'(busy_o), 96'(1));
      end
      if (k == TMO + RLEN) begin
        check("R6 reset ends", 96'(reset_o), 96'(0));
        check("R6 idle after", 96'(busy_o), 96'(0));
      end
    end
    check("R6 no verdict", 96'(val_rdy_o), 96'(0));
    res_vld_i = 1; res_acc_i = 1; tick(); res_vld_i = 0;
    check("R10 late verdict ignored", 96'(busy_o), 96'(0));
    check_scalers("R9 final");
    finish_run();
  end
endmodule